// File: doc/BRIEF.md
# Virtual Segment Access Checker

This block sorts each virtual address into a class before any translation lookup starts. It looks at the address, the current privilege level, whether the 64-bit address mode is on, and the error-level status bit. It reports one of four outcomes. The address may need the translation buffer. It may be a direct window, either cached or uncached, and then the block also gives the physical address. Otherwise it is an illegal access.

The address space splits into four regions, picked by the two top address bits. Region 3 splits again. Its top 2 GiB, the sign-extended 32-bit compatibility area, holds four 512 MiB segments. The rest of region 3 is a large mapped kernel area. The whole decision is combinational. It is followed by one output register, so a result appears one clock after its inputs. Downstream logic either starts a lookup, issues the physical access directly, or raises an address exception.

Top module: `vsac_top`

## Requirements
- R1: `cls_o` and `pa_o` are registered. They reflect the inputs sampled at the previous rising clock edge and do not move between edges. While `rst_ni` is low both read zero.
- R2: Class codes on `cls_o`: 0 = mapped, 1 = unmapped cached, 2 = unmapped uncached, 3 = address error. `pa_o` is zero whenever the class is 0 or 3. Privilege codes on `mode_i`: 0 = kernel, 1 = supervisor, 2 = user.
- R3: Region 0 (`va_i[63:62]`=0) gives an address error in 32-bit mode (`wide_i`=0) if any of `va_i[63:32]` is set. In 64-bit mode it gives an error if any of `va_i[61:40]` is set.
- R4: A legal region 0 address is mapped when `err_lvl_i`=0. When `err_lvl_i`=1 it is unmapped uncached with `pa_o` = `va_i[39:0]`. This holds at every privilege level.
- R5: Compatibility segment 0 (`va_i[63:31]` all ones, `va_i[30:29]`=0) is unmapped cached with `pa_o` = `va_i[28:0]`, in kernel mode only. Any other privilege level gives an error.
- R6: Compatibility segment 1 (`va_i[30:29]`=1) is unmapped uncached with `pa_o` = `va_i[28:0]` in kernel mode. Any other privilege level gives an error.
- R7: In the compatibility area, user mode always gets an error. Supervisor mode is legal only in segment 2 (`va_i[30:29]`=2), and that segment is mapped. Segment 3 is mapped and kernel only.
- R8: Region 3 below the compatibility area is legal only in kernel mode with `wide_i`=1. It is mapped when `va_i[61:0]` < 0xFF_8000_0000 and an error otherwise.
- R9: Region 2 is unmapped cached with `pa_o` = `va_i[39:0]` in kernel mode with `wide_i`=1. Otherwise it is an error.
- R10: Region 1 is mapped for kernel or supervisor mode with `wide_i`=1 and `va_i[61:40]` all zero. Otherwise it is an error.
- R11: Privilege code 3 is treated exactly as user mode.
- R12: Address error overrides every other outcome: `err_lvl_i` cannot turn an illegal region 0 address into an uncached one. `err_lvl_i` has no effect outside region 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| va_i | input | 64 | Virtual address |
| mode_i | input | 2 | Privilege level code |
| wide_i | input | 1 | 64-bit address mode enable |
| err_lvl_i | input | 1 | Error-level status bit |
| cls_o | output | 2 | Access class, registered |
| pa_o | output | 40 | Physical address for unmapped classes, zero otherwise |

## Verification
The only state is the output register, so a wrong decode shows at `cls_o` or `pa_o` on the very next clock edge. A fault shows either as a wrong class code or as physical bits that leak through on a mapped or faulting access. Segment and privilege boundaries are where faults hide: the end of the large kernel area, the edge of the compatibility area, and the upper bits that the 32-bit and 64-bit range checks test. The bench concentrates stimulus on those edges and checks every output one cycle after it drives the inputs.

// File: rtl/vsac_pkg.sv
package vsac_pkg;
  typedef enum logic [1:0] {
    CLS_MAPPED       = 2'd0,
    CLS_UNM_CACHED   = 2'd1,
    CLS_UNM_UNCACHED = 2'd2,
    CLS_ADDR_ERR     = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    PRIV_KERN = 2'd0,
    PRIV_SUPV = 2'd1,
    PRIV_USER = 2'd2,
    PRIV_RSVD = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    SEG_USER,   // region 0
    SEG_SUPX,   // region 1
    SEG_PHYS,   // region 2 direct window
    SEG_KERNX,  // region 3 below compat area
    SEG_KDIRC,  // compat 0: direct cached
    SEG_KDIRU,  // compat 1: direct uncached
    SEG_SUPC,   // compat 2: supervisor mapped
    SEG_KTOP    // compat 3: kernel mapped
  } seg_e;

  typedef struct packed {
    logic hi32_zero;
    logic wide_ok;
    logic kx_ok;
  } rng_t;
endpackage

// File: rtl/vsac_seg_decode.sv
module vsac_seg_decode
  import vsac_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int IMPL_VA_W = 40,
  parameter int CSEG_W    = 29
) (
  input  logic [VA_W-1:0] va_i,
  output seg_e            seg_o,
  output rng_t            rng_o
);
  localparam int ONES_LO = CSEG_W + 2;
  localparam logic [VA_W-3:0] ONE_X = {{(VA_W-3){1'b0}}, 1'b1};
  localparam logic [VA_W-3:0] KX_LIMIT = (ONE_X << IMPL_VA_W) - (ONE_X << ONES_LO);

  logic [1:0] region;
  logic [1:0] cidx;
  logic       in_compat;

  assign region    = va_i[VA_W-1:VA_W-2];
  assign cidx      = va_i[CSEG_W+1:CSEG_W];
  assign in_compat = &va_i[VA_W-1:ONES_LO];

  assign rng_o.hi32_zero = ~|va_i[VA_W-1:32];
  assign rng_o.kx_ok     = (va_i[VA_W-3:0] < KX_LIMIT);

  generate
    if (IMPL_VA_W < VA_W - 2) begin : g_wide_chk
      assign rng_o.wide_ok = ~|va_i[VA_W-3:IMPL_VA_W];
    end else begin : g_wide_full
      assign rng_o.wide_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (region)
      2'd0:    seg_o = SEG_USER;
      2'd1:    seg_o = SEG_SUPX;
      2'd2:    seg_o = SEG_PHYS;
      default: begin
        if (!in_compat) seg_o = SEG_KERNX;
        else begin
          unique case (cidx)
            2'd0:    seg_o = SEG_KDIRC;
            2'd1:    seg_o = SEG_KDIRU;
            2'd2:    seg_o = SEG_SUPC;
            default: seg_o = SEG_KTOP;
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/vsac_access_rules.sv
module vsac_access_rules
  import vsac_pkg::*;
(
  input  seg_e  seg_i,
  input  priv_e priv_i,
  input  logic  wide_i,
  input  logic  err_lvl_i,
  input  rng_t  rng_i,
  output logic  err_o,
  output cls_e  cls_o
);
  logic is_kern, is_supv;

  assign is_kern = (priv_i == PRIV_KERN);
  assign is_supv = (priv_i == PRIV_SUPV);  // RSVD falls to user (R11)

  always_comb begin
    err_o = 1'b1;
    cls_o = CLS_MAPPED;
    unique case (seg_i)
      SEG_USER: begin
        err_o = wide_i ? !rng_i.wide_ok : !rng_i.hi32_zero;
        cls_o = err_lvl_i ? CLS_UNM_UNCACHED : CLS_MAPPED;
      end
      SEG_SUPX: begin
        err_o = !wide_i || !(is_kern || is_supv) || !rng_i.wide_ok;
        cls_o = CLS_MAPPED;
      end
      SEG_PHYS: begin
        err_o = !wide_i || !is_kern;
        cls_o = CLS_UNM_CACHED;
      end
      SEG_KERNX: begin
        err_o = !wide_i || !is_kern || !rng_i.kx_ok;
        cls_o = CLS_MAPPED;
      end
      SEG_KDIRC: begin
        err_o = !is_kern;
        cls_o = CLS_UNM_CACHED;
      end
      SEG_KDIRU: begin
        err_o = !is_kern;
        cls_o = CLS_UNM_UNCACHED;
      end
      SEG_SUPC: begin
        err_o = !(is_kern || is_supv);
        cls_o = CLS_MAPPED;
      end
      SEG_KTOP: begin
        err_o = !is_kern;
        cls_o = CLS_MAPPED;
      end
      default: begin
        err_o = 1'b1;
        cls_o = CLS_MAPPED;
      end
    endcase
  end
endmodule

// File: rtl/vsac_pa_form.sv
module vsac_pa_form
  import vsac_pkg::*;
#(
  parameter int PA_W   = 40,
  parameter int CSEG_W = 29
) (
  input  seg_e            seg_i,
  input  logic [PA_W-1:0] va_lo_i,
  output logic [PA_W-1:0] pa_o
);
  logic [PA_W-1:0] dir_pa;

  generate
    if (PA_W > CSEG_W) begin : g_pad
      assign dir_pa = {{(PA_W-CSEG_W){1'b0}}, va_lo_i[CSEG_W-1:0]};
    end else begin : g_trunc
      assign dir_pa = va_lo_i;
    end
  endgenerate

  always_comb begin
    unique case (seg_i)
      SEG_USER, SEG_PHYS:   pa_o = va_lo_i;
      SEG_KDIRC, SEG_KDIRU: pa_o = dir_pa;  // segment base stripped
      default:              pa_o = '0;
    endcase
  end
endmodule

// File: rtl/vsac_top.sv
module vsac_top
  import vsac_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int IMPL_VA_W = 40,
  parameter int PA_W      = 40,
  parameter int CSEG_W    = 29
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [VA_W-1:0] va_i,
  input  logic [1:0]      mode_i,
  input  logic            wide_i,
  input  logic            err_lvl_i,
  output logic [1:0]      cls_o,
  output logic [PA_W-1:0] pa_o
);
  seg_e            seg;
  rng_t            rng;
  logic            rule_err;
  cls_e            rule_cls;
  logic [PA_W-1:0] raw_pa;
  cls_e            cls_d;
  logic [PA_W-1:0] pa_d;

  vsac_seg_decode #(
    .VA_W(VA_W), .IMPL_VA_W(IMPL_VA_W), .CSEG_W(CSEG_W)
  ) u_seg (
    .va_i (va_i),
    .seg_o(seg),
    .rng_o(rng)
  );

  vsac_access_rules u_rules (
    .seg_i    (seg),
    .priv_i   (priv_e'(mode_i)),
    .wide_i   (wide_i),
    .err_lvl_i(err_lvl_i),
    .rng_i    (rng),
    .err_o    (rule_err),
    .cls_o    (rule_cls)
  );

  vsac_pa_form #(
    .PA_W(PA_W), .CSEG_W(CSEG_W)
  ) u_pa (
    .seg_i  (seg),
    .va_lo_i(va_i[PA_W-1:0]),
    .pa_o   (raw_pa)
  );

  // error wins over any legal class
  assign cls_d = rule_err ? CLS_ADDR_ERR : rule_cls;
  assign pa_d  = (cls_d == CLS_UNM_CACHED || cls_d == CLS_UNM_UNCACHED) ? raw_pa : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_o <= 2'd0;
      pa_o  <= '0;
    end else begin
      cls_o <= cls_d;
      pa_o  <= pa_d;
    end
  end
endmodule

// File: rtl/vsac_chk.sv
module vsac_chk #(
  parameter int VA_W   = 64,
  parameter int PA_W   = 40,
  parameter int CSEG_W = 29
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [VA_W-1:0] va_i,
  input logic [1:0]      mode_i,
  input logic            wide_i,
  input logic            err_lvl_i,
  input logic [1:0]      cls_o,
  input logic [PA_W-1:0] pa_o
);
  logic compat, kdirc, user_lvl, r0, r2;

  assign compat   = &va_i[VA_W-1:CSEG_W+2];
  assign kdirc    = compat && (va_i[CSEG_W+1:CSEG_W] == 2'd0);
  assign user_lvl = mode_i[1];
  assign r0       = (va_i[VA_W-1:VA_W-2] == 2'd0);
  assign r2       = (va_i[VA_W-1:VA_W-2] == 2'd2);

  AST_PA_ZERO_NO_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_o == 2'd0 || cls_o == 2'd3) |-> (pa_o == '0)); // R2

  AST_NARROW_HI_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r0 && !wide_i && (va_i[VA_W-1:32] != '0)) |=> (cls_o == 2'd3)); // R3

  AST_ERRLVL_UNCACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r0 && !wide_i && err_lvl_i && (va_i[VA_W-1:32] == '0)) |=> (cls_o == 2'd2)); // R4

  AST_KDIRC_KERN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kdirc && mode_i != 2'd0) |=> (cls_o == 2'd3)); // R5

  AST_USER_COMPAT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (compat && user_lvl) |=> (cls_o == 2'd3)); // R7

  AST_PHYS_NARROW_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r2 && !wide_i) |=> (cls_o == 2'd3)); // R9
endmodule

bind vsac_top vsac_chk #(.VA_W(VA_W), .PA_W(PA_W), .CSEG_W(CSEG_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .va_i     (va_i),
  .mode_i   (mode_i),
  .wide_i   (wide_i),
  .err_lvl_i(err_lvl_i),
  .cls_o    (cls_o),
  .pa_o     (pa_o)
);

// File: tb/sim_vsac_top.sv
`timescale 1ns/1ps
module sim_vsac_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] va = '0;
  logic [1:0]  mode = '0;
  logic        wide = 1'b0;
  logic        erl = 1'b0;
  logic [1:0]  cls;
  logic [39:0] pa;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vsac_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .va_i(va), .mode_i(mode),
    .wide_i(wide), .err_lvl_i(erl), .cls_o(cls), .pa_o(pa)
  );

  function automatic logic [41:0] model(logic [63:0] a, logic [1:0] m, logic w, logic e);
    logic kern, supv, user;
    kern = (m == 2'd0); supv = (m == 2'd1); user = m[1];
    case (a[63:62])
      2'd0: begin
        if (!w && a[63:32] != 0) return {2'd3, 40'd0};
        if (w && a[61:40] != 0) return {2'd3, 40'd0};
        return e ? {2'd2, a[39:0]} : {2'd0, 40'd0};
      end
      2'd1: return (!w || user || a[61:40] != 0) ? {2'd3, 40'd0} : {2'd0, 40'd0};
      2'd2: return (w && kern) ? {2'd1, a[39:0]} : {2'd3, 40'd0};
      default: begin
        if (a >= 64'hFFFF_FFFF_8000_0000) begin
          case (a[31:29])
            3'd4: return kern ? {2'd1, 11'd0, a[28:0]} : {2'd3, 40'd0};
            3'd5: return kern ? {2'd2, 11'd0, a[28:0]} : {2'd3, 40'd0};
            3'd6: return (kern || supv) ? {2'd0, 40'd0} : {2'd3, 40'd0};
            default: return kern ? {2'd0, 40'd0} : {2'd3, 40'd0};
          endcase
        end
        if (w && kern && a[61:0] < 62'h00_00FF_8000_0000) return {2'd0, 40'd0};
        return {2'd3, 40'd0};
      end
    endcase
  endfunction

  function automatic string tag_of(logic [63:0] a);
    case (a[63:62])
      2'd0: return "R4";
      2'd1: return "R10";
      2'd2: return "R9";
      default: begin
        if (a < 64'hFFFF_FFFF_8000_0000) return "R8";
        case (a[31:29])
          3'd4: return "R5";
          3'd5: return "R6";
          default: return "R7";
        endcase
      end
    endcase
  endfunction

  task automatic chk(string tag, logic [41:0] ex);
    checks++;
    if (cls !== ex[41:40] || pa !== ex[39:0]) begin
      fails++;
      $display("FAIL %s: va=%h mode=%0d wide=%0b erl=%0b got cls=%0d pa=%h expected cls=%0d pa=%h",
               tag, va, mode, wide, erl, cls, pa, ex[41:40], ex[39:0]);
    end
  endtask

  task automatic one(string tag, logic [63:0] a, logic [1:0] m, logic w, logic e,
                     logic [1:0] xc, logic [39:0] xp);
    @(negedge clk);
    va = a; mode = m; wide = w; erl = e;
    @(posedge clk); #1;
    chk(tag, {xc, xp});
    if (model(a, m, w, e) !== {xc, xp}) begin
      fails++;
      $display("FAIL %s: model disagrees with directed expectation", tag);
    end
  endtask

  initial begin
    logic [41:0] prev;
    logic [41:0] ex;
    void'($urandom(32'd2024));
    va = 64'hFFFF_FFFF_8000_1234; mode = 2'd0; wide = 1'b1; erl = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset", {2'd0, 40'd0});
    @(negedge clk); rst_n = 1'b1;

    // directed corners
    one("R8 end-1", 64'hC000_00FF_7FFF_FFFF, 2'd0, 1'b1, 1'b0, 2'd0, 40'd0);
    one("R8 end",   64'hC000_00FF_8000_0000, 2'd0, 1'b1, 1'b0, 2'd3, 40'd0);
    one("R8 narrow", 64'hC000_0000_0000_0000, 2'd0, 1'b0, 1'b0, 2'd3, 40'd0);
    one("R8 supv",  64'hC000_0000_0000_1000, 2'd1, 1'b1, 1'b0, 2'd3, 40'd0);
    one("R3 narrow hi", 64'h0000_0001_0000_0000, 2'd2, 1'b0, 1'b0, 2'd3, 40'd0);
    one("R3 wide ok", 64'h0000_0001_0000_0000, 2'd2, 1'b1, 1'b0, 2'd0, 40'd0);
    one("R3 wide hi", 64'h0000_0100_0000_0000, 2'd0, 1'b1, 1'b1, 2'd3, 40'd0);
    one("R4 erl top", 64'h0000_00FF_FFFF_FFFF, 2'd2, 1'b1, 1'b1, 2'd2, 40'hFF_FFFF_FFFF);
    one("R12 erl err", 64'h0000_0001_0000_0000, 2'd0, 1'b0, 1'b1, 2'd3, 40'd0);
    one("R5 kern", 64'hFFFF_FFFF_9ABC_DEF0, 2'd0, 1'b0, 1'b0, 2'd1, 40'h00_1ABC_DEF0);
    one("R5 supv", 64'hFFFF_FFFF_8000_0000, 2'd1, 1'b1, 1'b0, 2'd3, 40'd0);
    one("R12 erl kseg", 64'hFFFF_FFFF_8000_0040, 2'd0, 1'b1, 1'b1, 2'd1, 40'h40);
    one("R6 kern", 64'hFFFF_FFFF_BFFF_FFFF, 2'd0, 1'b0, 1'b1, 2'd2, 40'h00_1FFF_FFFF);
    one("R6 supv", 64'hFFFF_FFFF_A000_0000, 2'd1, 1'b0, 1'b0, 2'd3, 40'd0);
    one("R7 supv seg", 64'hFFFF_FFFF_C000_0000, 2'd1, 1'b0, 1'b0, 2'd0, 40'd0);
    one("R7 user seg", 64'hFFFF_FFFF_DFFF_FFFF, 2'd2, 1'b1, 1'b0, 2'd3, 40'd0);
    one("R7 supv top", 64'hFFFF_FFFF_E000_0000, 2'd1, 1'b1, 1'b0, 2'd3, 40'd0);
    one("R7 kern top", 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b0, 1'b0, 2'd0, 40'd0);
    one("R9 kern", 64'h9000_0012_3456_789A, 2'd0, 1'b1, 1'b0, 2'd1, 40'h12_3456_789A);
    one("R9 supv", 64'h8000_0000_0000_0000, 2'd1, 1'b1, 1'b0, 2'd3, 40'd0);
    one("R10 supv", 64'h4000_00FF_FFFF_F000, 2'd1, 1'b1, 1'b0, 2'd0, 40'd0);
    one("R10 hi", 64'h4000_0100_0000_0000, 2'd0, 1'b1, 1'b0, 2'd3, 40'd0);
    one("R11 rsvd r1", 64'h4000_0000_0000_0000, 2'd3, 1'b1, 1'b0, 2'd3, 40'd0);
    one("R11 rsvd sseg", 64'hFFFF_FFFF_C000_0000, 2'd3, 1'b1, 1'b0, 2'd3, 40'd0);
    one("R2 mapped pa0", 64'h0000_0000_1234_5678, 2'd0, 1'b0, 1'b0, 2'd0, 40'd0);

    // random with latency checks
    prev = {2'd0, 40'd0};
    for (int i = 0; i < 800; i++) begin
      logic [63:0] a;
      logic [21:0] mid;
      mid = ($urandom_range(0, 3) == 0) ? 22'($urandom) : 22'd0;
      case ($urandom_range(0, 7))
        0: a = {32'd0, $urandom};
        1: a = {2'b00, mid, 8'($urandom), $urandom};
        2: a = {2'b01, mid, 8'($urandom), $urandom};
        3: a = {2'b10, 30'($urandom), $urandom};
        4: a = {32'hFFFF_FFFF, 1'b1, 31'($urandom)};
        5: a = 64'hC000_00FF_8000_0000 - 64'd8 + 64'($urandom_range(0, 15));
        6: a = {2'b11, 30'($urandom), $urandom};
        default: a = {$urandom, $urandom};
      endcase
      @(negedge clk);
      va = a; mode = 2'($urandom); wide = 1'($urandom); erl = 1'($urandom);
      ex = model(a, mode, wide, erl);
      #1;
      if (i > 0) chk("R1 hold", prev);
      @(posedge clk); #1;
      chk(tag_of(a), ex);
      prev = ex;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule